// File: doc/BRIEF.md
# Distributed Rotating-Priority Bus Arbiter

This block is the arbitration logic that each agent on a shared multi-master bus carries. Up to eight processors, each with a fixed 3-bit identity, share one bus with a host. Every agent drives only the request line picked by its identity, and it observes all eight lines. Every copy holds the same state and sees the same shared inputs, so every copy reaches the same decision on the same clock edge. No central arbiter exists.

Priority rotates. After a master gives up the bus, the search for the next master starts at the identity just above it. Several rules act on top of the rotation:

- A shared lock line holds the current master in place for indivisible read-modify-write sequences.
- A fairness rule stops a master from keeping the bus once other agents are waiting.
- A host request takes the bus at the next transaction boundary.
- A back-off input makes the master let go mid-transaction when that transaction targets host address space.

The testbench builds a complete bus from eight copies. The data path and address decoding are outside the block.

Top module: `bus_arb_agent`

## Requirements
- R1: `req_n_o` is low while `want` is high and high otherwise. The system wires it to request line `agent_id` (identity 0 to line 0, identity 7 to line 7). Lines that no agent uses are held high.
- R2: After reset, no agent is master, host grant is low, and the search starts at line 0. With every agent requesting, identity 0 wins first.
- R3: After master k releases the bus, the next winner is the first active request line found in the order k+1, k+2, …, wrapping from 7 to 0.
- R4: When the bus is idle and at least one request is active, the winner's `master_o` is high after the next clock edge. It is high in exactly one copy.
- R5: A master whose transaction ends (`bus_done`) keeps the bus when no other line requests, host request is low and its own request is still active.
- R6: When `bus_done` is high, the lock line is low and any other line is requesting, the master releases. The bus is idle for one cycle. The next winner is chosen by the rotation of R3, so the old master waits behind the other requesters.
- R7: While the shared lock line `bus_lock` is high, the master keeps the bus regardless of `bus_done`, other requests or a host request.
- R8: A host request does not interrupt a transaction in progress. At the next `bus_done` without lock, the master releases and `host_grant_o` rises after that edge. Grant stays high while `host_req` stays high. After `host_req` falls, one edge clears the grant and the bus is idle, and the next edge grants by rotation.
- R9: `back_off` together with `host_space` makes the master release at the next edge, even under lock. When `host_req` is high the host grant rises on that same edge.
- R10: `back_off` without `host_space` has no effect on the master.
- R11: `lock_o` is high only in the copy that is master and has `want_lock` high.

Here `bus_done`, `bus_lock`, `host_req`, `back_off` and `host_space` are shared inputs that every copy receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| agent_id | input | IDW (3) | This agent's identity, stable outside reset |
| want | input | 1 | This agent wants the bus |
| want_lock | input | 1 | This agent, once master, wants a locked sequence |
| req_lines_n | input | N_AGENTS (8) | All request lines, active low |
| bus_lock | input | 1 | Shared lock line (OR of every agent's `lock_o`) |
| bus_done | input | 1 | Current master's transaction completes this cycle |
| host_req | input | 1 | Host asks for the bus |
| back_off | input | 1 | Host deadlock-recovery request |
| host_space | input | 1 | Current transaction targets host address space |
| req_n_o | output | 1 | This agent's request line, active low |
| master_o | output | 1 | This agent owns the bus |
| lock_o | output | 1 | This agent holds the lock line |
| host_grant_o | output | 1 | Host owns the bus |

## Verification
A request line follows `want` within the same cycle, and so does `lock_o` once the agent is master. Every change in ownership appears one clock edge after the cycle in which the bus saw the inputs that cause it. A release is always followed by one idle edge before the next winner appears. The bench changes inputs 2 ns after a rising edge and reads outputs 2 ns after the next rising edge. For that reason each sample shows the result of exactly one edge. Expected winners in the sweep come from a first-set-bit search that starts one identity above the previous master.

// File: rtl/bus_arb_agent.sv
module bus_arb_agent #(
  parameter int N_AGENTS = 8,
  localparam int IDW = $clog2(N_AGENTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDW-1:0]      agent_id,
  input  logic                want,
  input  logic                want_lock,
  input  logic [N_AGENTS-1:0] req_lines_n,
  input  logic                bus_lock,
  input  logic                bus_done,
  input  logic                host_req,
  input  logic                back_off,
  input  logic                host_space,
  output logic                req_n_o,
  output logic                master_o,
  output logic                lock_o,
  output logic                host_grant_o
);

  logic           owned, host_own;
  logic [IDW-1:0] cur, ptr, winner, cur_next;
  logic           found;

  wire [N_AGENTS-1:0] active  = ~req_lines_n;
  wire                any_req = |active;
  wire                others  = |(active & ~(N_AGENTS'(1) << cur));
  wire                cur_req = active[cur];
  wire                drop_bo = back_off & host_space;
  wire                drop_ok = bus_done & ~bus_lock & (host_req | others | ~cur_req);

  assign cur_next = (cur == IDW'(N_AGENTS - 1)) ? '0 : cur + 1'b1;

  always_comb begin
    winner = '0;
    found  = 1'b0;
    for (int k = 0; k < N_AGENTS; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N_AGENTS;
      if (!found && active[idx]) begin
        winner = IDW'(idx);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owned    <= 1'b0;
      host_own <= 1'b0;
      cur      <= '0;
      ptr      <= '0;
    end else if (host_own) begin
      if (!host_req) host_own <= 1'b0;
    end else if (owned) begin
      if (drop_bo || drop_ok) begin
        owned    <= 1'b0;
        host_own <= host_req;
        ptr      <= cur_next;
      end
    end else if (host_req) begin
      host_own <= 1'b1;
    end else if (any_req) begin
      owned <= 1'b1;
      cur   <= winner;
    end
  end

  assign req_n_o      = ~want;
  assign master_o     = owned && (cur == agent_id);
  assign lock_o       = master_o && want_lock;
  assign host_grant_o = host_own;

endmodule

module bus_arb_agent_chk (
  input logic clk,
  input logic rst_n,
  input logic req_n_o,
  input logic master_o,
  input logic host_grant_o,
  input logic host_req,
  input logic bus_lock,
  input logic back_off,
  input logic host_space
);

  assert_win_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_o) |-> $past(!req_n_o));

  assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    master_o && bus_lock && !(back_off && host_space) |=> master_o);

  assert_backoff_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    master_o && back_off && host_space |=> !master_o);

  assert_host_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    master_o |-> !host_grant_o);

  assert_host_grant_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_grant_o) |-> $past(host_req));

  assert_host_grant_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant_o && host_req |=> host_grant_o);

endmodule

bind bus_arb_agent bus_arb_agent_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_n_o(req_n_o), .master_o(master_o),
  .host_grant_o(host_grant_o), .host_req(host_req), .bus_lock(bus_lock),
  .back_off(back_off), .host_space(host_space)
);

// File: tb/bus_arb_agent_tb_top.sv
`timescale 1ns/1ps
module bus_arb_agent_tb_top;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] want = '0, wlock = '0;
  logic bus_done = 0, host_req = 0, back_off = 0, host_space = 0;
  wire  [N-1:0] req_lines, m_vec, l_vec, hg_vec;
  wire  bus_lock = |l_vec;
  int   total = 0, bad = 0;
  bit   finished = 0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_ag
    bus_arb_agent #(.N_AGENTS(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .agent_id(3'(g)), .want(want[g]),
      .want_lock(wlock[g]), .req_lines_n(req_lines), .bus_lock(bus_lock),
      .bus_done(bus_done), .host_req(host_req), .back_off(back_off),
      .host_space(host_space), .req_n_o(req_lines[g]), .master_o(m_vec[g]),
      .lock_o(l_vec[g]), .host_grant_o(hg_vec[g])
    );
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  function automatic int first_from(input int start, input logic [N-1:0] mask);
    for (int k = 0; k < N; k++) if (mask[(start + k) % N]) return (start + k) % N;
    return -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    chk("R2 reset master", m_vec, 0);
    chk("R2 reset host grant", hg_vec, 0);
    chk("R1 idle lines", req_lines, 8'hFF);
    rst_n = 1;

    want = 8'h24; #1;
    chk("R1 line follows id", req_lines, 8'hDB);
    cyc();
    chk("R2 first from line 0", m_vec, 8'h04);

    want = 8'h04; bus_done = 1; cyc();
    chk("R5 parked", m_vec, 8'h04);
    bus_done = 0;

    wlock = 8'h0C; #1;
    chk("R11 lock only master", l_vec, 8'h04);
    want = 8'hFF; host_req = 1; bus_done = 1; cyc();
    chk("R7 locked keeps bus", m_vec, 8'h04);
    chk("R7 host waits on lock", hg_vec, 0);
    cyc();
    chk("R7 still locked", m_vec, 8'h04);

    back_off = 1; host_space = 0; cyc();
    chk("R10 backoff ignored", m_vec, 8'h04);
    host_space = 1; cyc();
    chk("R9 backoff releases", m_vec, 0);
    chk("R9 host granted", hg_vec, 8'hFF);
    back_off = 0; host_space = 0; bus_done = 0; wlock = 0;

    cyc();
    chk("R8 grant holds", hg_vec, 8'hFF);
    chk("R8 no master under host", m_vec, 0);
    host_req = 0; cyc();
    chk("R8 grant cleared", hg_vec, 0);
    chk("R8 idle after host", m_vec, 0);
    cyc();
    chk("R3 rotate after 2", m_vec, 8'h08);

    host_req = 1; cyc();
    chk("R8 no mid-transfer preempt", m_vec, 8'h08);
    chk("R8 grant waits", hg_vec, 0);
    bus_done = 1; cyc();
    chk("R8 host at done", hg_vec, 8'hFF);
    chk("R8 master released", m_vec, 0);
    host_req = 0; bus_done = 0; cyc();
    chk("R8 idle", m_vec, 0);
    cyc();
    chk("R3 rotate after 3", m_vec, 8'h10);

    back_off = 1; host_space = 1; cyc();
    chk("R9 release without host", m_vec, 0);
    chk("R9 no grant without request", hg_vec, 0);
    back_off = 0; host_space = 0; want = 0; cyc();
    chk("R9 idle", m_vec, 0);

    want = 8'h01; cyc();
    chk("R4 lone requester", m_vec, 8'h01);
    want = 8'h81; bus_done = 1; cyc();
    chk("R6 fairness release", m_vec, 0);
    bus_done = 0; cyc();
    chk("R6 waiter served first", m_vec, 8'h80);
    want = 0; bus_done = 1; cyc(); bus_done = 0; cyc();

    for (int m = 0; m < N; m++) begin
      for (int k = 0; k < 8; k++) begin
        logic [N-1:0] mask;
        int exp_w;
        mask = 8'((m * 37 + k * 91 + 5) & 8'hFF);
        mask[m] = 1'b0;
        if (mask == 0) mask[(m + 3) % N] = 1'b1;
        exp_w = first_from((m + 1) % N, mask);
        want = 8'(1 << m); cyc();
        chk("R4 single grant", m_vec, 1 << m);
        want = mask; bus_done = 1; cyc();
        chk("R6 release idle", m_vec, 0);
        bus_done = 0; cyc();
        chk("R3 rotated winner", m_vec, 1 << exp_w);
        want = 0; bus_done = 1; cyc();
        bus_done = 0;
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule